// File: doc/BRIEF.md
# Host Channel Transfer Progress Tracker

This block keeps the transfer state of a single USB host channel while a transfer is running. Software loads a byte count, a packet count, a starting packet ID, a direction, the endpoint's maximum packet size and two flags: one for split transactions and one for an interrupt endpoint. It then enables the channel. A transaction-engine stub reports each finished packet with a strobe, and for IN packets it also reports the number of bytes received. It can instead report a NAK.

For each packet the tracker updates the remaining byte count, the remaining packet count and the next data packet ID. When the transfer finishes, or when it is stopped, the channel halts. A halted channel stays idle until software enables it again. With split transactions, the packets alternate between a start phase and a complete phase, and the counters move only on the complete phase. The current state is presented as one 32-bit transfer word so that software can read how far the transfer has progressed.

Top module: `xfer_progress_tracker`

## Requirements
- R1: After reset the channel is inactive, and the halted, completed and NAK flags are all 0. The transfer word and the split phase are also 0.
- R2: A load pulse while the channel is inactive places the programmed fields in the transfer word: remaining bytes in bits 18:0, packet count in bits 28:19 and packet ID in bits 30:29. Bit 31 (ping) always reads 0. A load also clears the halted, completed and NAK flags and the split phase.
- R3: A counted IN packet reduces the byte count by the number of bytes received, saturating at 0. It also reduces the packet count by 1.
- R4: A counted OUT packet leaves the byte count unchanged and reduces the packet count by 1.
- R5: Packet ID codes are DATA0=0, DATA2=1, DATA1=2 and SETUP/MDATA=3. A counted packet turns DATA0 into DATA1 and DATA1 into DATA0. Codes 1 and 3 stay unchanged.
- R6: With splits enabled, the first packet after an enable is a start split. A start split sets the split phase to 1 and changes no counter. The next packet is a complete split: it is counted and returns the split phase to 0.
- R7: When a counted packet brings the packet count to 0, the channel goes inactive and both the halted and completed flags are set.
- R8: An IN packet shorter than the maximum packet size completes the transfer in the same way. That packet is still counted.
- R9: A NAK on an IN transfer to an interrupt endpoint halts the channel with the NAK flag set, the completed flag clear and the counters unchanged. A NAK on any other transfer has no effect.
- R10: A disable pulse on an active channel halts it without setting the completed flag and leaves the counters unchanged.
- R11: Packet reports and NAKs that arrive while the channel is inactive have no effect.
- R12: A zero-byte IN transfer is programmed with a packet count of 1. It completes on a 0-byte packet, and its byte count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Load the programmed fields (accepted only while inactive) |
| cfgSize | input | 19 | Transfer size in bytes |
| cfgPktCnt | input | 10 | Packet count |
| cfgPid | input | 2 | Starting packet ID code |
| cfgDirIn | input | 1 | 1 for an IN transfer, 0 for an OUT transfer |
| cfgMaxPkt | input | 11 | Endpoint maximum packet size |
| cfgSplitEn | input | 1 | Enable split transactions |
| cfgIntrEp | input | 1 | Endpoint is an interrupt endpoint |
| chEnable | input | 1 | Start the channel |
| chDisable | input | 1 | Force the channel to halt |
| pktDone | input | 1 | Engine stub finished one packet |
| pktBytes | input | 11 | Bytes received in that packet (IN only) |
| pktNak | input | 1 | Engine stub received a NAK |
| xferWord | output | 32 | Transfer word: size, packet count, packet ID, ping |
| active | output | 1 | Channel is running |
| halted | output | 1 | Channel has halted |
| completed | output | 1 | Transfer completed |
| nakFlag | output | 1 | Halt was caused by a NAK |
| splitPhase | output | 1 | 1 when the next packet is a complete split |

## Verification
The bench checks that the byte count stays fixed on OUT packets. A design that decremented it anyway would report bytes that were never sent. The bench also checks that a start split changes no counter and no packet ID; an early advance would count every split packet twice. It covers a short IN packet that ends a transfer while packets remain, where a design missing this would wait for data that never comes, and a 0-byte transfer that must finish with its size still at 0. It also confirms that the DATA2 and SETUP codes stay fixed and that only an interrupt-IN NAK halts the channel. A broken toggle would corrupt the data sequence, and a NAK halt on a bulk endpoint would stop a transfer that should simply retry.

// File: rtl/xfer_tracker_pkg.sv
package xfer_tracker_pkg;
  localparam int SIZE_W = 19;
  localparam int CNT_W  = 10;
  localparam int PID_W  = 2;
  localparam int MPS_W  = 11;

  typedef enum logic [PID_W-1:0] {
    PID_DATA0 = 2'd0,
    PID_DATA2 = 2'd1,
    PID_DATA1 = 2'd2,
    PID_SETUP = 2'd3
  } pidCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_tracker_pkg::*;
#(
  parameter int SizeW = SIZE_W,
  parameter int CntW  = CNT_W,
  parameter int PidW  = PID_W,
  parameter int MpsW  = MPS_W,
  localparam int WordW = SizeW + CntW + PidW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [SizeW-1:0] cfgSize,
  input  logic [CntW-1:0]  cfgPktCnt,
  input  logic [PidW-1:0]  cfgPid,
  input  logic             cfgDirIn,
  input  logic [MpsW-1:0]  cfgMaxPkt,
  input  logic [MpsW-1:0]  pktBytes,
  output logic [WordW-1:0] xferWord,
  output logic             lastPkt
);
  logic [SizeW-1:0] sizeQ, sizeNext, bytesExt;
  logic [CntW-1:0]  cntQ, cntNext;
  logic [PidW-1:0]  pidQ, pidNext;
  logic             dirInQ;
  logic [MpsW-1:0]  maxPktQ;

  assign bytesExt = SizeW'(pktBytes);

  always_comb begin
    sizeNext = sizeQ;
    if (dirInQ) sizeNext = (bytesExt >= sizeQ) ? '0 : sizeQ - bytesExt;
    cntNext = (cntQ == '0) ? '0 : cntQ - 1'b1;
    case (pidQ)
      PidW'(PID_DATA0): pidNext = PidW'(PID_DATA1);
      PidW'(PID_DATA1): pidNext = PidW'(PID_DATA0);
      default:          pidNext = pidQ;
    endcase
  end

  assign lastPkt = (cntQ <= CntW'(1)) || (dirInQ && (pktBytes < maxPktQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ   <= '0;
      cntQ    <= '0;
      pidQ    <= '0;
      dirInQ  <= 1'b0;
      maxPktQ <= '0;
    end else if (strobe.load) begin
      sizeQ   <= cfgSize;
      cntQ    <= cfgPktCnt;
      pidQ    <= cfgPid;
      dirInQ  <= cfgDirIn;
      maxPktQ <= cfgMaxPkt;
    end else if (strobe.advance) begin
      sizeQ <= sizeNext;
      cntQ  <= cntNext;
      pidQ  <= pidNext;
    end
  end

  assign xferWord = {1'b0, pidQ, cntQ, sizeQ};

  // R4
  out_size_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load && !dirInQ) |=> $stable(sizeQ));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load && cntQ != '0) |=> (cntQ == $past(cntQ) - 1'b1));
  // R5
  pid_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load && (pidQ == PidW'(PID_SETUP) || pidQ == PidW'(PID_DATA2)))
      |=> $stable(pidQ));
  // R2
  ping_zero_chk: assert property (@(posedge clk) disable iff (!rstN) !xferWord[WordW-1]);
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_tracker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgLoad,
  input  logic      cfgDirIn,
  input  logic      cfgSplitEn,
  input  logic      cfgIntrEp,
  input  logic      chEnable,
  input  logic      chDisable,
  input  logic      pktDone,
  input  logic      pktNak,
  input  logic      lastPkt,
  output dpStrobe_t strobe,
  output logic      active,
  output logic      halted,
  output logic      completed,
  output logic      nakFlag,
  output logic      splitPhase
);
  logic splitEnQ, intrEpQ, dirInQ;
  logic nakHalts, countIt, startSplit;

  assign nakHalts   = active && pktNak && intrEpQ && dirInQ;
  assign startSplit = active && !chDisable && !pktNak && pktDone && splitEnQ && !splitPhase;
  assign countIt    = active && !chDisable && !pktNak && pktDone && !(splitEnQ && !splitPhase);

  assign strobe.load    = cfgLoad && !active;
  assign strobe.advance = countIt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      halted     <= 1'b0;
      completed  <= 1'b0;
      nakFlag    <= 1'b0;
      splitPhase <= 1'b0;
      splitEnQ   <= 1'b0;
      intrEpQ    <= 1'b0;
      dirInQ     <= 1'b0;
    end else if (!active) begin
      if (cfgLoad) begin
        splitEnQ   <= cfgSplitEn;
        intrEpQ    <= cfgIntrEp;
        dirInQ     <= cfgDirIn;
        halted     <= 1'b0;
        completed  <= 1'b0;
        nakFlag    <= 1'b0;
        splitPhase <= 1'b0;
      end else if (chEnable) begin
        active     <= 1'b1;
        halted     <= 1'b0;
        completed  <= 1'b0;
        nakFlag    <= 1'b0;
        splitPhase <= 1'b0;
      end
    end else if (chDisable) begin
      active <= 1'b0;
      halted <= 1'b1;
    end else if (nakHalts) begin
      active  <= 1'b0;
      halted  <= 1'b1;
      nakFlag <= 1'b1;
    end else if (startSplit) begin
      splitPhase <= 1'b1;
    end else if (countIt) begin
      splitPhase <= 1'b0;
      if (lastPkt) begin
        active    <= 1'b0;
        halted    <= 1'b1;
        completed <= 1'b1;
      end
    end
  end

  // R7
  complete_implies_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    completed |-> (halted && !active));
  // R6
  start_split_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSplit |=> (splitPhase && active));
  // R6
  no_count_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && splitEnQ) |-> splitPhase);
  // R10
  disable_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && chDisable) |=> (halted && !active && !completed));
  // R11
  idle_no_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !strobe.advance);
endmodule

// File: rtl/xfer_progress_tracker.sv
module xfer_progress_tracker
  import xfer_tracker_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [SIZE_W-1:0] cfgSize,
  input  logic [CNT_W-1:0]  cfgPktCnt,
  input  logic [PID_W-1:0]  cfgPid,
  input  logic              cfgDirIn,
  input  logic [MPS_W-1:0]  cfgMaxPkt,
  input  logic              cfgSplitEn,
  input  logic              cfgIntrEp,
  input  logic              chEnable,
  input  logic              chDisable,
  input  logic              pktDone,
  input  logic [MPS_W-1:0]  pktBytes,
  input  logic              pktNak,
  output logic [31:0]       xferWord,
  output logic              active,
  output logic              halted,
  output logic              completed,
  output logic              nakFlag,
  output logic              splitPhase
);
  dpStrobe_t strobe;
  logic      lastPkt;

  xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgDirIn(cfgDirIn),
    .cfgSplitEn(cfgSplitEn), .cfgIntrEp(cfgIntrEp), .chEnable(chEnable),
    .chDisable(chDisable), .pktDone(pktDone), .pktNak(pktNak), .lastPkt(lastPkt),
    .strobe(strobe), .active(active), .halted(halted), .completed(completed),
    .nakFlag(nakFlag), .splitPhase(splitPhase)
  );

  xfer_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgSize(cfgSize),
    .cfgPktCnt(cfgPktCnt), .cfgPid(cfgPid), .cfgDirIn(cfgDirIn),
    .cfgMaxPkt(cfgMaxPkt), .pktBytes(pktBytes), .xferWord(xferWord),
    .lastPkt(lastPkt)
  );
endmodule

// File: tb/tb_xfer_progress_tracker.sv
module tb_xfer_progress_tracker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 0, cfgDirIn = 0, cfgSplitEn = 0, cfgIntrEp = 0;
  logic [18:0] cfgSize = 0;
  logic [9:0]  cfgPktCnt = 0;
  logic [1:0]  cfgPid = 0;
  logic [10:0] cfgMaxPkt = 0, pktBytes = 0;
  logic        chEnable = 0, chDisable = 0, pktDone = 0, pktNak = 0;
  logic [31:0] xferWord;
  logic        active, halted, completed, nakFlag, splitPhase;

  int testCnt = 0, failCnt = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    logic [31:0] word;
    logic [4:0]  flags; // active, halted, completed, nak, phase
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  xfer_progress_tracker dut (.*);

  // monitor: compare queued expectations just after the sampling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (expQ.size() > 0) begin
      expItem_t e;
      logic [4:0] got;
      e = expQ.pop_front();
      got = {active, halted, completed, nakFlag, splitPhase};
      testCnt++;
      if (xferWord !== e.word || got !== e.flags) begin
        failCnt++;
        $display("FAIL %s: word=%h flags=%b expected word=%h flags=%b",
                 e.tag, xferWord, got, e.word, e.flags);
      end
    end
  end

  task automatic expect_state(input string tag, input int sz, input int cnt, input int pid,
                              input bit a, input bit h, input bit c, input bit n, input bit p);
    expItem_t e;
    e.tag = tag;
    e.word = {1'b0, 2'(pid), 10'(cnt), 19'(sz)};
    e.flags = {a, h, c, n, p};
    expQ.push_back(e);
  endtask

  task automatic load(input int sz, input int cnt, input int pid, input bit dirIn,
                      input int mps, input bit split, input bit intr);
    @(negedge clk);
    cfgSize = 19'(sz); cfgPktCnt = 10'(cnt); cfgPid = 2'(pid); cfgDirIn = dirIn;
    cfgMaxPkt = 11'(mps); cfgSplitEn = split; cfgIntrEp = intr; cfgLoad = 1;
    @(negedge clk);
    cfgLoad = 0;
  endtask

  task automatic enable();
    @(negedge clk); chEnable = 1;
    @(negedge clk); chEnable = 0;
  endtask

  task automatic pkt(input int bytes);
    @(negedge clk); pktDone = 1; pktBytes = 11'(bytes);
    @(negedge clk); pktDone = 0;
  endtask

  task automatic nak();
    @(negedge clk); pktNak = 1;
    @(negedge clk); pktNak = 0;
  endtask

  task automatic stop();
    @(negedge clk); chDisable = 1;
    @(negedge clk); chDisable = 0;
  endtask

  initial begin
    #(5 * 100000);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_state("R1 reset", 0, 0, 0, 0, 0, 0, 0, 0);
    rstN = 1;
    @(negedge clk);

    // IN bulk: two packets, second short
    load(100, 2, 0, 1, 64, 0, 0);
    expect_state("R2 load fields", 100, 2, 0, 0, 0, 0, 0, 0);
    enable();
    expect_state("R2 enable", 100, 2, 0, 1, 0, 0, 0, 0);
    pkt(64);
    expect_state("R3 R5 IN packet", 36, 1, 2, 1, 0, 0, 0, 0);
    pkt(36);
    expect_state("R7 R3 last IN packet", 0, 0, 0, 0, 1, 1, 0, 0);
    pkt(10);
    expect_state("R11 packet while idle", 0, 0, 0, 0, 1, 1, 0, 0);

    // OUT: size held, then forced halt
    load(200, 4, 2, 0, 64, 0, 0);
    enable();
    pkt(0);
    expect_state("R4 R5 OUT packet", 200, 3, 0, 1, 0, 0, 0, 0);
    pkt(0);
    expect_state("R4 second OUT packet", 200, 2, 2, 1, 0, 0, 0, 0);
    stop();
    expect_state("R10 forced halt", 200, 2, 2, 0, 1, 0, 0, 0);
    nak();
    expect_state("R11 NAK while idle", 200, 2, 2, 0, 1, 0, 0, 0);

    // short IN ends early, DATA2 fixed
    load(300, 5, 1, 1, 64, 0, 0);
    enable();
    pkt(10);
    expect_state("R8 R5 short IN", 290, 4, 1, 0, 1, 1, 0, 0);

    // SETUP code stays
    load(8, 1, 3, 0, 64, 0, 0);
    enable();
    pkt(8);
    expect_state("R5 R7 SETUP OUT", 8, 0, 3, 0, 1, 1, 0, 0);

    // split IN
    load(128, 2, 0, 1, 64, 1, 0);
    enable();
    pkt(64);
    expect_state("R6 start split no count", 128, 2, 0, 1, 0, 0, 0, 1);
    pkt(64);
    expect_state("R6 complete split counts", 64, 1, 2, 1, 0, 0, 0, 0);
    pkt(64);
    expect_state("R6 second start split", 64, 1, 2, 1, 0, 0, 0, 1);
    pkt(64);
    expect_state("R6 R7 final complete split", 0, 0, 0, 0, 1, 1, 0, 0);

    // NAK on bulk IN ignored, NAK on interrupt IN halts
    load(64, 1, 0, 1, 64, 0, 0);
    enable();
    nak();
    expect_state("R9 bulk NAK ignored", 64, 1, 0, 1, 0, 0, 0, 0);
    stop();
    load(8, 1, 2, 1, 8, 0, 1);
    enable();
    nak();
    expect_state("R9 interrupt IN NAK", 8, 1, 2, 0, 1, 0, 1, 0);
    load(8, 1, 2, 0, 8, 0, 1);
    expect_state("R2 load clears flags", 8, 1, 2, 0, 0, 0, 0, 0);
    enable();
    nak();
    expect_state("R9 interrupt OUT NAK ignored", 8, 1, 2, 1, 0, 0, 0, 0);
    stop();

    // zero-byte IN
    load(0, 1, 2, 1, 64, 0, 0);
    enable();
    pkt(0);
    expect_state("R12 zero-byte IN", 0, 0, 0, 0, 1, 1, 0, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule